// File: doc/BRIEF.md
# Interleaved Board Address Mapper

This block sits on a memory board and watches word addresses issued on the processor memory bus. For each request it decides whether the board owns that word. When it does, it produces the 18-bit physical array address as a 9-bit row part (X) and a 9-bit column part (Y). Software programs a 12-bit mapper register with three things: a map-out flag, a 6-bit board code and a 3-bit interleave mode.

With interleaving off, a board owns a contiguous window of 2^18 words chosen by the board code. With 2-, 4- or 8-way interleaving, the lowest one, two or three word-address bits select a board in rotation, so consecutive words fall on different boards. The remaining code bits are compared with the address bits above the physical field. The rotation bits are dropped before the physical address is formed. Any address bit above the compared range must be zero for a hit.

Top module: `board_addr_mapper`

## Requirements
- R1: After reset the hit output is 0, X and Y are 0, and the map-out flag is set, so a request issued before any register write does not hit.
- R2: When mapper register bit 0 (map-out) is 1, no request produces a hit, whatever the address, code or mode.
- R3: In mode 000 (register bits 11:9, no interleave), a request hits exactly when address bits 23:18 equal the code in register bits 8:3 and address bits 26:24 are zero. The physical address is address bits 17:0.
- R4: In mode 001 (2-way), a request hits exactly when address bit 0 equals code bit 0, address bits 23:19 equal code bits 5:1, and address bits 26:24 are zero. The physical address is address bits 18:1, so even and odd words go to boards whose code bit 0 differs.
- R5: In mode 010 (4-way), a request hits exactly when address bits 1:0 equal code bits 1:0, address bits 23:20 equal code bits 5:2, and address bits 26:24 are zero. The physical address is address bits 19:2.
- R6: In mode 011 (8-way), a request hits exactly when address bits 2:0 equal code bits 2:0, address bits 23:21 equal code bits 5:3, and address bits 26:24 are zero. The physical address is address bits 20:3.
- R7: Modes 100 to 111 are unsupported, and no request hits while one of them is configured.
- R8: X is the upper 9 bits of the 18-bit physical address and Y is the lower 9 bits.
- R9: The hit output is high for exactly the one cycle after a request that matches. It is low in every cycle that does not follow a request.
- R10: X and Y are loaded on every request, hit or not, and hold their value in cycles that follow no request.
- R11: A register write in the same cycle as a request does not affect that request. It applies from the next request on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Request strobe for the address on laddr |
| laddr | input | 27 | Logical word address |
| cfg_we | input | 1 | Mapper register write enable |
| cfg_wdata | input | 12 | Mapper register write value: bit 0 map-out, bits 8:3 board code, bits 11:9 mode |
| hit | output | 1 | Registered: the board owns the last requested word |
| phys_x | output | 9 | Registered physical row address |
| phys_y | output | 9 | Registered physical column address |

## Verification
The bench sweeps runs of consecutive word addresses under each interleave mode. Exactly one of every 2, 4 or 8 neighbours should hit, which separates a correct rotation compare from one that uses the wrong low bits or none. Addresses that match the low code bits but differ in the upper code bits, or that have bits 26:24 set, separate the upper compare from the lane compare. Known physical values catch a shift by the wrong amount or swapped X and Y halves. A request in the same cycle as a register write, a map-out setting and an unsupported mode with otherwise matching addresses show that the register gates the compare with the right timing.

// File: rtl/bmap_pkg.sv
package bmap_pkg;
  localparam int CODE_W     = 6;
  localparam int MODE_W     = 3;
  localparam int CFG_W      = 12;
  localparam int NUM_MODES  = 4;
  localparam int MODE_IDX_W = $clog2(NUM_MODES);

  typedef struct packed {
    logic [MODE_W-1:0] mode;
    logic [CODE_W-1:0] code;
    logic [1:0]        spare;
    logic              map_out;
  } map_cfg_t;
endpackage

// File: rtl/bmap_cfg_reg.sv
module bmap_cfg_reg
  import bmap_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [CFG_W-1:0] wdata,
  output map_cfg_t         cfg
);
  map_cfg_t cfg_d;
  map_cfg_t cfg_q;

  always_comb begin
    cfg_d = cfg_q;
    if (we) cfg_d = map_cfg_t'(wdata);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '{mode: '0, code: '0, spare: '0, map_out: 1'b1};
    end else begin
      cfg_q <= cfg_d;
    end
  end

  assign cfg = cfg_q;
endmodule

// File: rtl/bmap_decode.sv
module bmap_decode
  import bmap_pkg::*;
#(
  parameter int ADDR_W = 27,
  parameter int PHYS_W = 18
) (
  input  logic [ADDR_W-1:0] laddr,
  input  map_cfg_t          cfg,
  output logic              match,
  output logic [PHYS_W-1:0] phys
);
  logic [NUM_MODES-1:0] sel_ok;
  logic [PHYS_W-1:0]    sel_phys [NUM_MODES];

  for (genvar s = 0; s < NUM_MODES; s++) begin : g_mode
    localparam logic [ADDR_W-1:0] LMASK = (ADDR_W'(1) << s) - ADDR_W'(1);
    logic [ADDR_W-1:0] shifted;
    logic              lane_ok;
    logic              upper_ok;
    assign shifted  = laddr >> s;
    assign lane_ok  = ((laddr ^ ADDR_W'(cfg.code)) & LMASK) == '0;
    assign upper_ok = (shifted >> PHYS_W) == (ADDR_W'(cfg.code) >> s);
    assign sel_ok[s]   = lane_ok & upper_ok;
    assign sel_phys[s] = shifted[PHYS_W-1:0];
  end

  always_comb begin
    match = 1'b0;
    phys  = sel_phys[0];
    if (cfg.mode < MODE_W'(NUM_MODES)) begin
      match = sel_ok[cfg.mode[MODE_IDX_W-1:0]];
      phys  = sel_phys[cfg.mode[MODE_IDX_W-1:0]];
    end
  end
endmodule

// File: rtl/board_addr_mapper.sv
module board_addr_mapper
  import bmap_pkg::*;
#(
  parameter int ADDR_W = 27,
  parameter int X_W    = 9,
  parameter int Y_W    = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req,
  input  logic [ADDR_W-1:0] laddr,
  input  logic             cfg_we,
  input  logic [CFG_W-1:0] cfg_wdata,
  output logic             hit,
  output logic [X_W-1:0]   phys_x,
  output logic [Y_W-1:0]   phys_y
);
  localparam int PHYS_W = X_W + Y_W;

  map_cfg_t          cfg;
  logic              match;
  logic [PHYS_W-1:0] phys_c;

  logic              hit_d, hit_q;
  logic [PHYS_W-1:0] phys_d, phys_q;

  bmap_cfg_reg u_cfg (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (cfg_we),
    .wdata (cfg_wdata),
    .cfg   (cfg)
  );

  bmap_decode #(.ADDR_W(ADDR_W), .PHYS_W(PHYS_W)) u_dec (
    .laddr (laddr),
    .cfg   (cfg),
    .match (match),
    .phys  (phys_c)
  );

  always_comb begin
    hit_d  = req & match & ~cfg.map_out;
    phys_d = phys_q;
    if (req) phys_d = phys_c;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hit_q  <= 1'b0;
      phys_q <= '0;
    end else begin
      hit_q  <= hit_d;
      phys_q <= phys_d;
    end
  end

  assign hit    = hit_q;
  assign phys_x = phys_q[PHYS_W-1:Y_W];
  assign phys_y = phys_q[Y_W-1:0];
endmodule

// File: rtl/board_addr_mapper_chk.sv
module board_addr_mapper_chk
  import bmap_pkg::*;
#(
  parameter int ADDR_W = 27,
  parameter int X_W    = 9,
  parameter int Y_W    = 9
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req,
  input logic [ADDR_W-1:0] laddr,
  input logic             cfg_we,
  input logic [CFG_W-1:0] cfg_wdata,
  input logic             hit,
  input logic [X_W-1:0]   phys_x,
  input logic [Y_W-1:0]   phys_y
);
  logic              mo_q;
  logic [MODE_W-1:0] mode_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mo_q   <= 1'b1;
      mode_q <= '0;
    end else if (cfg_we) begin
      mo_q   <= cfg_wdata[0];
      mode_q <= cfg_wdata[11:9];
    end
  end

  always @(posedge clk) begin
    if (!rst_n) p_reset_quiet_r1: assert (!hit && phys_x == '0 && phys_y == '0);
  end

  p_mapped_out_r2: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> !$past(mo_q));

  p_flat_phys_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && $past(mode_q) == 3'd0) |-> ({phys_x, phys_y} == $past(laddr[X_W+Y_W-1:0])));

  p_bad_mode_r7: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> !$past(mode_q[2]));

  p_hit_follows_req_r9: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> $past(req));

  p_phys_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(req) |-> ($stable(phys_x) && $stable(phys_y)));
endmodule

bind board_addr_mapper board_addr_mapper_chk #(.ADDR_W(ADDR_W), .X_W(X_W), .Y_W(Y_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req       (req),
  .laddr     (laddr),
  .cfg_we    (cfg_we),
  .cfg_wdata (cfg_wdata),
  .hit       (hit),
  .phys_x    (phys_x),
  .phys_y    (phys_y)
);

// File: tb/board_addr_mapper_tb.sv
module board_addr_mapper_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0;
  logic [26:0] laddr = '0;
  logic        cfg_we = 1'b0;
  logic [11:0] cfg_wdata = '0;
  logic        hit;
  logic [8:0]  phys_x, phys_y;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [11:0] cur_cfg = 12'h001;

  always #2 clk = ~clk;

  board_addr_mapper u_dut (
    .clk(clk), .rst_n(rst_n), .req(req), .laddr(laddr),
    .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .hit(hit), .phys_x(phys_x), .phys_y(phys_y)
  );

  function automatic bit exp_hit(input logic [11:0] c, input logic [26:0] a);
    logic [5:0] code;
    code = c[8:3];
    if (c[0]) return 0;
    if (a[26:24] != 3'b000) return 0;
    case (c[11:9])
      3'd0: return a[23:18] == code;
      3'd1: return (a[0] == code[0]) && (a[23:19] == code[5:1]);
      3'd2: return (a[1:0] == code[1:0]) && (a[23:20] == code[5:2]);
      3'd3: return (a[2:0] == code[2:0]) && (a[23:21] == code[5:3]);
      default: return 0;
    endcase
  endfunction

  function automatic logic [17:0] exp_phys(input logic [11:0] c, input logic [26:0] a);
    case (c[11:9])
      3'd1: return a[18:1];
      3'd2: return a[19:2];
      3'd3: return a[20:3];
      default: return a[17:0];
    endcase
  endfunction

  function automatic logic [11:0] mk_cfg(input bit mo, input logic [5:0] code, input logic [2:0] mode);
    return {mode, code, 2'b00, mo};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr_cfg(input logic [11:0] v);
    @(negedge clk);
    cfg_we = 1'b1; cfg_wdata = v;
    @(negedge clk);
    cfg_we = 1'b0;
    cur_cfg = v;
  endtask

  task automatic do_req(input logic [26:0] a);
    @(negedge clk);
    req = 1'b1; laddr = a;
    @(negedge clk);
    req = 1'b0;
  endtask

  task automatic req_check(input logic [26:0] a, input string tag);
    bit eh;
    logic [17:0] ep;
    eh = exp_hit(cur_cfg, a);
    ep = exp_phys(cur_cfg, a);
    do_req(a);
    chk(hit == eh, tag, {31'b0, hit}, {31'b0, eh});
    chk({phys_x, phys_y} == ep, {tag, " R8 phys"}, {14'b0, phys_x, phys_y}, {14'b0, ep});
  endtask

  task automatic t_reset;
    chk(hit == 1'b0 && phys_x == 0 && phys_y == 0, "R1 reset outputs", {14'b0, hit, phys_x, phys_y}, 0);
    do_req(27'h0);
    chk(hit == 1'b0, "R1 mapped out after reset", {31'b0, hit}, 0);
  endtask

  task automatic t_mapout;
    wr_cfg(mk_cfg(1'b1, 6'h00, 3'd0));
    do_req(27'h0_0123);
    chk(hit == 1'b0, "R2 map-out flat", {31'b0, hit}, 0);
    wr_cfg(mk_cfg(1'b1, 6'h05, 3'd1));
    do_req({3'b0, 5'h02, 18'h0_0AB, 1'b1});
    chk(hit == 1'b0, "R2 map-out 2-way", {31'b0, hit}, 0);
  endtask

  task automatic t_flat;
    wr_cfg(mk_cfg(1'b0, 6'h15, 3'd0));
    req_check({3'b000, 6'h15, 18'h2_A5C3}, "R3 flat match");
    req_check({3'b000, 6'h15, 18'h1_0F0F}, "R3 flat match 2");
    req_check({3'b000, 6'h14, 18'h2_A5C3}, "R3 flat code mismatch");
    req_check({3'b010, 6'h15, 18'h0_0001}, "R3 flat high bits set");
  endtask

  task automatic t_interleave(input logic [2:0] mode, input logic [5:0] code, input string tag);
    int hits;
    logic [26:0] base;
    int n;
    n = 1 << mode;
    wr_cfg(mk_cfg(1'b0, code, mode));
    base = {3'b000, 24'(code) >> mode << mode, 18'h0} >> mode;
    base = ({3'b000, 24'(code >> mode) << (18 + mode)}) | (27'h1_2345 << mode);
    hits = 0;
    for (int i = 0; i < 2 * n; i++) begin
      req_check(base + 27'(i), tag);
      if (hit) hits++;
    end
    chk(hits == 2, {tag, " one hit per rotation"}, hits, 2);
    req_check(base ^ (27'h1 << 23), {tag, " upper code mismatch"});
  endtask

  task automatic t_bad_mode;
    for (int m = 4; m < 8; m++) begin
      wr_cfg(mk_cfg(1'b0, 6'h00, 3'(m)));
      do_req(27'h0_0000);
      chk(hit == 1'b0, "R7 unsupported mode", {31'b0, hit}, 0);
    end
  endtask

  task automatic t_timing;
    logic [8:0] hx, hy;
    wr_cfg(mk_cfg(1'b0, 6'h01, 3'd0));
    do_req({3'b0, 6'h01, 9'h155, 9'h0AA});
    chk(hit == 1'b1, "R9 hit one cycle after req", {31'b0, hit}, 1);
    chk(phys_x == 9'h155 && phys_y == 9'h0AA, "R8 X/Y split", {14'b0, phys_x, phys_y}, {14'b0, 9'h155, 9'h0AA});
    hx = phys_x; hy = phys_y;
    @(negedge clk);
    chk(hit == 1'b0, "R9 hit single cycle", {31'b0, hit}, 0);
    laddr = 27'h7FF_FFFF;
    @(negedge clk);
    @(negedge clk);
    chk(phys_x == hx && phys_y == hy, "R10 phys hold without req", {14'b0, phys_x, phys_y}, {14'b0, hx, hy});
    do_req({3'b0, 6'h02, 18'h0_0777});
    chk(hit == 1'b0 && {phys_x, phys_y} == 18'h0_0777, "R10 phys load on miss", {13'b0, hit, phys_x, phys_y}, {14'b0, 18'h0_0777});
  endtask

  task automatic t_same_cycle;
    wr_cfg(mk_cfg(1'b0, 6'h0A, 3'd0));
    @(negedge clk);
    req = 1'b1; laddr = {3'b0, 6'h0A, 18'h0_1234};
    cfg_we = 1'b1; cfg_wdata = mk_cfg(1'b1, 6'h0A, 3'd0);
    @(negedge clk);
    req = 1'b0; cfg_we = 1'b0;
    chk(hit == 1'b1, "R11 old cfg used", {31'b0, hit}, 1);
    do_req({3'b0, 6'h0A, 18'h0_1234});
    chk(hit == 1'b0, "R11 new cfg next req", {31'b0, hit}, 0);
    cur_cfg = mk_cfg(1'b1, 6'h0A, 3'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_mapout();
    t_flat();
    t_interleave(3'd1, 6'h2B, "R4 2-way");
    t_interleave(3'd2, 6'h2B, "R5 4-way");
    t_interleave(3'd3, 6'h2E, "R6 8-way");
    t_bad_mode();
    t_timing();
    t_same_cycle();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule